// File: doc/BRIEF.md
# Approximate-Load Miss Value Predictor

This block lets an out-of-order core keep going when a load that software has marked as approximate misses in the data cache. It does not wait for memory. It looks up a small direct-mapped table, indexed by a hash of the load PC, and produces a guessed value. The guess is delivered tagged with the load's destination physical register, together with a wakeup strobe for dependent instructions. The load then retires like any other load. The block never checks whether the guess was right and never asks for a replay.

The memory request for a predicted load is still issued. When the fill data comes back, it trains the table entry for that PC, whatever has become of the load that asked for it.

Each entry holds:
- a partial PC tag,
- the last value seen,
- a candidate stride,
- a prediction stride.

By default the training rule is two-delta. A parameter selects plain stride training instead.

Top module: `rfvp_top`

## Requirements
- R1: After rst_ni is released, pred_valid_o and wakeup_o are low and every table entry is untrained.
- R2: A prediction is made only for an issue cycle with ld_valid_i, ld_approx_i and ld_miss_i all high. A cache hit (ld_miss_i low), a precise load (ld_approx_i low) or an idle port (ld_valid_i low) never yields one.
- R3: In two-delta mode, a matching fill computes delta = data − last value. The prediction stride takes delta only when delta equals the stored candidate stride; otherwise it keeps its value. The candidate stride then becomes delta, and the last value becomes data.
- R4: The predicted value is last value + prediction stride, modulo 2^DATA_W. pred_valid_o and wakeup_o are high for exactly the one cycle after the issue cycle. In that cycle pred_preg_o carries the ld_preg_i of the issue cycle.
- R5: A fill (fill_valid_i high) only trains the table. It never raises pred_valid_o itself, and it is applied without any comparison against earlier predictions.
- R6: A fill whose tag differs from the stored tag, or that lands on an untrained entry, allocates the entry. The new tag is stored, last value = data, and both strides are zero. After this, loads with the former tag no longer hit.
- R7: The table index is ld_pc[9:2] XOR ld_pc[17:10]. The tag is an XOR fold, in 8-bit chunks, of {pc[31:18], pc[1:0]}. These figures are for the defaults of 256 entries and an 8-bit tag.
- R8: When an approximate-miss lookup and a fill hit the same entry in the same cycle, the lookup uses the entry state from before that fill. The fill takes effect for later lookups.
- R9: With MODE set to stride, every matching fill replaces the prediction stride with delta.
- R10: A load whose tag does not match the indexed entry, or whose entry is untrained, gets no prediction (pred_valid_o stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | A load is issued this cycle |
| ld_pc_i | input | PC_W | PC of the issued load |
| ld_approx_i | input | 1 | Load is the approximate variant |
| ld_miss_i | input | 1 | Load missed in the data cache |
| ld_preg_i | input | PREG_W | Destination physical register of the load |
| fill_valid_i | input | 1 | Memory data returns this cycle |
| fill_pc_i | input | PC_W | PC of the load that requested the fill |
| fill_data_i | input | DATA_W | Returned data |
| pred_valid_o | output | 1 | Predicted value is valid |
| pred_preg_o | output | PREG_W | Destination register for the predicted value |
| pred_value_o | output | DATA_W | Predicted value |
| wakeup_o | output | 1 | Wakeup broadcast strobe for dependents |

## Verification
A lookup for an approximate miss and a fill training the same entry can land in the same cycle. The bench provokes this by driving both ports on one clock edge to the index of a trained entry, using a fill value that changes the entry's state. It judges the result in two steps. First, the prediction that appears on the next cycle must equal the value computed from the pre-fill entry. Second, a later lookup must return the value computed from the post-fill entry.

// File: rtl/rfvp_pkg.sv
package rfvp_pkg;
  typedef enum logic {
    MODE_TWO_DELTA = 1'b0,
    MODE_STRIDE    = 1'b1
  } train_mode_e;
endpackage

// File: rtl/rfvp_hash.sv
module rfvp_hash #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8,
  parameter int TAG_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int HI_LO  = 2 + 2 * IDX_W;
  localparam int FOLD_W = PC_W - HI_LO + 2;
  localparam int CHUNKS = (FOLD_W + TAG_W - 1) / TAG_W;
  localparam int PAD_W  = CHUNKS * TAG_W;

  logic [PAD_W-1:0] fold_src;
  logic [TAG_W-1:0] part [CHUNKS];

  assign idx_o    = pc_i[2 +: IDX_W] ^ pc_i[2 + IDX_W +: IDX_W];
  assign fold_src = PAD_W'({pc_i[PC_W-1:HI_LO], pc_i[1:0]});

  genvar g;
  generate
    for (g = 0; g < CHUNKS; g++) begin : g_fold
      if (g == 0) begin : g_first
        assign part[g] = fold_src[0 +: TAG_W];
      end else begin : g_rest
        assign part[g] = part[g-1] ^ fold_src[g*TAG_W +: TAG_W];
      end
    end
  endgenerate

  assign tag_o = part[CHUNKS-1];
endmodule

// File: rtl/rfvp_train.sv
module rfvp_train #(
  parameter int                    DATA_W = 64,
  parameter rfvp_pkg::train_mode_e MODE   = rfvp_pkg::MODE_TWO_DELTA
) (
  input  logic [DATA_W-1:0] last_i,
  input  logic [DATA_W-1:0] cand_i,
  input  logic [DATA_W-1:0] pstr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] cand_o,
  output logic [DATA_W-1:0] pstr_o,
  output logic              match_o
);
  logic [DATA_W-1:0] delta;

  always_comb begin
    delta   = data_i - last_i;
    match_o = (delta == cand_i);
    cand_o  = delta;
    if (MODE == rfvp_pkg::MODE_STRIDE || match_o) pstr_o = delta;
    else                                          pstr_o = pstr_i;
  end
endmodule

// File: rtl/rfvp_table.sv
module rfvp_table #(
  parameter int                    IDX_W  = 8,
  parameter int                    TAG_W  = 8,
  parameter int                    DATA_W = 64,
  parameter rfvp_pkg::train_mode_e MODE   = rfvp_pkg::MODE_TWO_DELTA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_value_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int ENTRIES = 1 << IDX_W;

  logic              vld_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [DATA_W-1:0] last_q [ENTRIES];
  logic [DATA_W-1:0] cand_q [ENTRIES];
  logic [DATA_W-1:0] pstr_q [ENTRIES];

  logic              wr_alloc;
  logic [DATA_W-1:0] new_cand, new_pstr;
  logic              stride_match;

  // lookup reads state before any same-cycle write
  assign rd_hit_o   = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_value_o = last_q[rd_idx_i] + pstr_q[rd_idx_i];

  assign wr_alloc = !vld_q[wr_idx_i] || (tag_q[wr_idx_i] != wr_tag_i);

  rfvp_train #(.DATA_W(DATA_W), .MODE(MODE)) u_train (
    .last_i (last_q[wr_idx_i]),
    .cand_i (cand_q[wr_idx_i]),
    .pstr_i (pstr_q[wr_idx_i]),
    .data_i (wr_data_i),
    .cand_o (new_cand),
    .pstr_o (new_pstr),
    .match_o(stride_match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
    end else if (wr_en_i) begin
      vld_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      last_q[wr_idx_i] <= wr_data_i;
      cand_q[wr_idx_i] <= wr_alloc ? '0 : new_cand;
      pstr_q[wr_idx_i] <= wr_alloc ? '0 : new_pstr;
    end
  end

  assert_alloc_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_alloc) |=>
      (pstr_q[$past(wr_idx_i)] == '0) && (cand_q[$past(wr_idx_i)] == '0)
      && (last_q[$past(wr_idx_i)] == $past(wr_data_i)));

  generate
    if (MODE == rfvp_pkg::MODE_TWO_DELTA) begin : g_td_chk
      assert_hold_stride_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_alloc && !stride_match) |=>
          pstr_q[$past(wr_idx_i)] == $past(pstr_q[wr_idx_i]));
    end else begin : g_st_chk
      assert_replace_stride_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_alloc) |=>
          pstr_q[$past(wr_idx_i)] == $past(wr_data_i - last_q[wr_idx_i]));
    end
  endgenerate
endmodule

// File: rtl/rfvp_top.sv
module rfvp_top #(
  parameter int                    PC_W   = 32,
  parameter int                    DATA_W = 64,
  parameter int                    PREG_W = 7,
  parameter int                    IDX_W  = 8,
  parameter int                    TAG_W  = 8,
  parameter rfvp_pkg::train_mode_e MODE   = rfvp_pkg::MODE_TWO_DELTA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [PC_W-1:0]   ld_pc_i,
  input  logic              ld_approx_i,
  input  logic              ld_miss_i,
  input  logic [PREG_W-1:0] ld_preg_i,
  input  logic              fill_valid_i,
  input  logic [PC_W-1:0]   fill_pc_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              pred_valid_o,
  output logic [PREG_W-1:0] pred_preg_o,
  output logic [DATA_W-1:0] pred_value_o,
  output logic              wakeup_o
);
  logic [IDX_W-1:0]  lk_idx, fl_idx;
  logic [TAG_W-1:0]  lk_tag, fl_tag;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_value;
  logic              fire;

  rfvp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_lk (
    .pc_i(ld_pc_i), .idx_o(lk_idx), .tag_o(lk_tag));

  rfvp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_fl (
    .pc_i(fill_pc_i), .idx_o(fl_idx), .tag_o(fl_tag));

  rfvp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .MODE(MODE)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (lk_idx),
    .rd_tag_i  (lk_tag),
    .rd_hit_o  (lk_hit),
    .rd_value_o(lk_value),
    .wr_en_i   (fill_valid_i),
    .wr_idx_i  (fl_idx),
    .wr_tag_i  (fl_tag),
    .wr_data_i (fill_data_i)
  );

  assign fire = ld_valid_i && ld_approx_i && ld_miss_i && lk_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      wakeup_o     <= 1'b0;
      pred_preg_o  <= '0;
      pred_value_o <= '0;
    end else begin
      pred_valid_o <= fire;
      wakeup_o     <= fire;
      if (fire) begin
        pred_preg_o  <= ld_preg_i;
        pred_value_o <= lk_value;
      end
    end
  end

  assert_pred_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> $past(ld_valid_i && ld_approx_i && ld_miss_i));

  assert_pred_preg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> pred_preg_o == $past(ld_preg_i));

  assert_wakeup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_o == pred_valid_o);

  assert_no_fill_pred_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !ld_valid_i) |=> !pred_valid_o);
endmodule

// File: tb/tb_rfvp_top.sv
module tb_rfvp_top;
  localparam int PC_W = 32, DATA_W = 64, PREG_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, ld_approx = 0, ld_miss = 0, fill_valid = 0;
  logic [PC_W-1:0]   ld_pc = '0, fill_pc = '0;
  logic [PREG_W-1:0] ld_preg = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              pv, wk, s_pv, s_wk;
  logic [PREG_W-1:0] pp, s_pp;
  logic [DATA_W-1:0] pval, s_pval;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rfvp_top dut (
    .clk_i(clk), .rst_ni(rst_n), .ld_valid_i(ld_valid), .ld_pc_i(ld_pc),
    .ld_approx_i(ld_approx), .ld_miss_i(ld_miss), .ld_preg_i(ld_preg),
    .fill_valid_i(fill_valid), .fill_pc_i(fill_pc), .fill_data_i(fill_data),
    .pred_valid_o(pv), .pred_preg_o(pp), .pred_value_o(pval), .wakeup_o(wk));

  rfvp_top #(.MODE(rfvp_pkg::MODE_STRIDE)) dut_stride (
    .clk_i(clk), .rst_ni(rst_n), .ld_valid_i(ld_valid), .ld_pc_i(ld_pc),
    .ld_approx_i(ld_approx), .ld_miss_i(ld_miss), .ld_preg_i(ld_preg),
    .fill_valid_i(fill_valid), .fill_pc_i(fill_pc), .fill_data_i(fill_data),
    .pred_valid_o(s_pv), .pred_preg_o(s_pp), .pred_value_o(s_pval), .wakeup_o(s_wk));

  function automatic logic [PC_W-1:0] pc_of(input int idx, input int tsel);
    return PC_W'((tsel << 20) | (idx << 2));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_ld;
    ld_valid = 0; ld_approx = 0; ld_miss = 0;
  endtask

  // issue one load, check the output in the following cycle
  task automatic issue(input logic [PC_W-1:0] pc, input bit ap, input bit ms, input int preg,
                       input bit exp_v, input logic [63:0] exp_val, input string req);
    @(negedge clk);
    ld_valid = 1; ld_pc = pc; ld_approx = ap; ld_miss = ms; ld_preg = PREG_W'(preg);
    @(negedge clk);
    clr_ld();
    chk(pv == exp_v, req, 64'(pv), 64'(exp_v));
    chk(wk == exp_v, {req, " wakeup"}, 64'(wk), 64'(exp_v));
    if (exp_v) begin
      chk(pval == exp_val, {req, " value"}, pval, exp_val);
      chk(pp == PREG_W'(preg), {req, " preg"}, 64'(pp), 64'(preg));
    end
  endtask

  task automatic fill(input logic [PC_W-1:0] pc, input logic [63:0] d);
    @(negedge clk);
    fill_valid = 1; fill_pc = pc; fill_data = d;
    @(negedge clk);
    fill_valid = 0;
    chk(pv == 0, "R5 fill raises no prediction", 64'(pv), 0);
  endtask

  task automatic t_reset;
    chk(pv == 0 && wk == 0, "R1 outputs low after reset", 64'(pv | wk), 0);
    issue(pc_of(8'h20, 1), 1, 1, 3, 0, 0, "R1 untrained after reset");
  endtask

  task automatic t_two_delta;
    logic [PC_W-1:0] pc = pc_of(8'h10, 1);
    issue(pc, 1, 1, 5, 0, 0, "R10 untrained entry no prediction");
    fill(pc, 100);
    issue(pc, 1, 1, 5, 1, 100, "R6 allocated entry predicts last value");
    fill(pc, 110);
    issue(pc, 1, 1, 6, 1, 110, "R3 first stride not adopted");
    fill(pc, 120);
    issue(pc, 1, 1, 7, 1, 130, "R3 repeated stride adopted R4");
    fill(pc, 125);
    issue(pc, 1, 1, 8, 1, 135, "R3 single new stride ignored");
    fill(pc, 130);
    issue(pc, 1, 1, 9, 1, 135, "R3 new stride adopted after repeat");
  endtask

  task automatic t_gating;
    logic [PC_W-1:0] pc = pc_of(8'h10, 1);
    issue(pc, 1, 0, 10, 0, 0, "R2 cache hit no prediction");
    issue(pc, 0, 1, 11, 0, 0, "R2 precise load no prediction");
    @(negedge clk);
    ld_valid = 0; ld_pc = pc; ld_approx = 1; ld_miss = 1;
    @(negedge clk);
    clr_ld();
    chk(pv == 0, "R2 idle port no prediction", 64'(pv), 0);
  endtask

  task automatic t_same_cycle;
    logic [PC_W-1:0] pc = pc_of(8'h10, 1);
    @(negedge clk);
    ld_valid = 1; ld_pc = pc; ld_approx = 1; ld_miss = 1; ld_preg = 7'd20;
    fill_valid = 1; fill_pc = pc; fill_data = 140;
    @(negedge clk);
    clr_ld(); fill_valid = 0;
    chk(pv == 1 && pval == 135, "R8 lookup sees pre-fill state", pval, 135);
    issue(pc, 1, 1, 21, 1, 145, "R8 fill visible afterwards");
  endtask

  task automatic t_tag;
    logic [PC_W-1:0] pa = pc_of(8'h10, 1);
    logic [PC_W-1:0] pb = pc_of(8'h10, 2);
    issue(pb, 1, 1, 30, 0, 0, "R10 tag mismatch no prediction");
    fill(pb, 500);
    issue(pb, 1, 1, 31, 1, 500, "R6 new tag allocated strides zero");
    issue(pa, 1, 1, 32, 0, 0, "R6 former tag evicted");
  endtask

  task automatic t_hash;
    logic [PC_W-1:0] ph = PC_W'((8'h0F << 2) | (8'hF0 << 10));
    fill(ph, 777);
    issue(PC_W'(8'hFF << 2), 1, 1, 40, 1, 777, "R7 xor index folds pc bits");
    issue(PC_W'(8'h0F << 2), 1, 1, 41, 0, 0, "R7 low bits alone differ in index");
  endtask

  task automatic t_back_to_back;
    logic [PC_W-1:0] pb = pc_of(8'h10, 2);
    logic [PC_W-1:0] ph = PC_W'(8'hFF << 2);
    @(negedge clk);
    ld_valid = 1; ld_pc = pb; ld_approx = 1; ld_miss = 1; ld_preg = 7'd50;
    @(negedge clk);
    chk(pv && pval == 500 && pp == 7'd50, "R4 first of pair", pval, 500);
    ld_pc = ph; ld_preg = 7'd51;
    @(negedge clk);
    clr_ld();
    chk(pv && pval == 777 && pp == 7'd51, "R4 second of pair", pval, 777);
    @(negedge clk);
    chk(pv == 0, "R4 strobe lasts one cycle", 64'(pv), 0);
  endtask

  task automatic t_stride;
    logic [PC_W-1:0] pc = pc_of(8'h40, 3);
    fill(pc, 100);
    fill(pc, 110);
    fill(pc, 115);
    @(negedge clk);
    ld_valid = 1; ld_pc = pc; ld_approx = 1; ld_miss = 1; ld_preg = 7'd60;
    @(negedge clk);
    clr_ld();
    chk(s_pv && s_pval == 120, "R9 stride mode replaces stride", s_pval, 120);
    chk(pv && pval == 115, "R3 two-delta keeps zero stride", pval, 115);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_two_delta();
    t_gating();
    t_same_cycle();
    t_tag();
    t_hash();
    t_back_to_back();
    t_stride();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule